// File: doc/BRIEF.md
# Single-Level Linear Page Translator

This block maps a 16-bit virtual address to a 15-bit physical address through a flat table of sixteen entries held in registers inside the block. The top four address bits choose an entry. The low twelve bits form the offset within a 4 KB page and pass through untouched. Each entry is a 4-bit word: bit 0 marks the page as present, and bits 3:1 give the physical frame number. That frame number becomes the top of the physical address.

Software fills the table through a write port made of an index, a data word and an enable. A translation is started by raising the request strobe together with a virtual address. One clock later the block pulses exactly one of two outputs. The valid pulse carries the physical address. The fault pulse means the selected page is not present, and in that case no address is presented.

For example, if entry 2 holds binary 1101, then virtual address 0x2004 translates to physical address 0x6004.

Top module: `lpt_translator`

## Requirements
- R1: After a synchronous active-low reset, both response outputs are low and every table entry reads as zero, so every translation faults until the table is written.
- R2: Virtual address bits 15:12 select which of the sixteen entries is used for the translation.
- R3: For a present entry, the physical address is the entry's bits 3:1 placed at physical bits 14:12, with virtual bits 11:0 copied to physical bits 11:0.
- R4: Each request sampled at a clock edge produces its response on the outputs right after that edge. The response lasts for that one cycle only. Requests on consecutive cycles give consecutive responses.
- R5: If the selected entry has bit 0 clear, the response is a fault pulse, the valid output stays low and the physical address is zero.
- R6: A table write takes effect at the clock edge that samples it. A translation sampled at the same edge reads the entry's previous content.
- R7: In a cycle after an edge that sampled no request, the valid and fault outputs are both low.
- R8: The valid and fault outputs are never high together.
- R9: The physical address output is zero whenever the valid output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Table write enable |
| wr_idx | input | 4 | Entry index to write |
| wr_data | input | 4 | Entry word: bit 0 present, bits 3:1 frame |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle pulse: translation succeeded |
| rsp_fault | output | 1 | One-cycle pulse: selected page not present |
| rsp_paddr | output | 15 | Physical address, zero unless rsp_valid is high |

## Verification
Every response is due one clock edge after the edge that samples its request. A table write is visible to requests sampled from the following edge onward. The bench drives each cycle's inputs at the falling edge and computes the expected response from its own table model before applying that cycle's write. It then compares valid, fault and address at the next falling edge, half a period after the rising edge that registered them. Requests on consecutive cycles, idle cycles and a write and read of the same entry at the same edge are all checked in this single-cycle frame.

// File: rtl/lpt_pkg.sv
// Package: shared widths and the response outcome type for the linear
// page translator. Assumes one-level tables with a present flag in bit 0.
package lpt_pkg;

    // Default geometry of the translator
    localparam int LPT_VA_W  = 16;
    localparam int LPT_OFF_W = 12;
    localparam int LPT_ENT_W = 4;

    // Registered outcome of one translation slot
    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_HIT   = 2'd1,
        OUT_FAULT = 2'd2
    } lpt_outcome_e;

endpackage

// File: rtl/lpt_table_regs.sv
// Module: register file holding the page-table entries.
// Assumes one write port and one combinational read port. A write lands at
// the sampling edge, so a read in the same cycle returns the old word.
module lpt_table_regs #(
    parameter int IDX_W = 4,
    parameter int ENT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_entry
);
    localparam int NUM_ENT = 1 << IDX_W;

    logic [ENT_W-1:0] ent_vec [NUM_ENT];

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_entry
        logic             sel;
        logic [ENT_W-1:0] ent_r;

        // Decode whether this entry is the write target
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        // Hold one entry word, cleared on reset, loaded when selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_r <= '0;
            end else if (sel) begin
                ent_r <= wr_data;
            end
        end

        assign ent_vec[g] = ent_r;
    end

    // Select the entry addressed by the read index
    assign rd_entry = ent_vec[rd_idx];

endmodule

// File: rtl/lpt_addr_split.sv
// Module: splits a virtual address into table index and page offset.
// Assumes the index occupies all bits above the offset.
module lpt_addr_split #(
    parameter int VA_W  = 16,
    parameter int OFF_W = 12
) (
    input  logic [VA_W-1:0]       vaddr,
    output logic [VA_W-OFF_W-1:0] idx,
    output logic [OFF_W-1:0]      offset
);
    // Cut the address at the page boundary
    assign idx    = vaddr[VA_W-1:OFF_W];
    assign offset = vaddr[OFF_W-1:0];

endmodule

// File: rtl/lpt_result_stage.sv
// Module: checks the present flag and registers the one-cycle response.
// Assumes entry bit 0 is the present flag and the remaining bits are the
// frame number. The address output is zero unless the response is a hit.
module lpt_result_stage #(
    parameter int ENT_W = 4,
    parameter int OFF_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ENT_W-1:0]         entry,
    input  logic [OFF_W-1:0]         offset,
    output logic                     rsp_valid,
    output logic                     rsp_fault,
    output logic [ENT_W-1+OFF_W-1:0] rsp_paddr
);
    import lpt_pkg::*;

    localparam int FRAME_W = ENT_W - 1;
    localparam int PA_W    = FRAME_W + OFF_W;

    lpt_outcome_e     outcome_d, outcome_q;
    logic [PA_W-1:0]  paddr_d, paddr_q;

    // Classify the request and assemble the candidate physical address
    always_comb begin
        outcome_d = OUT_NONE;
        paddr_d   = '0;
        if (req_valid) begin
            if (entry[0]) begin
                outcome_d = OUT_HIT;
                paddr_d   = {entry[ENT_W-1:1], offset};
            end else begin
                outcome_d = OUT_FAULT;
            end
        end
    end

    // Register the outcome so each response lasts exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outcome_q <= OUT_NONE;
            paddr_q   <= '0;
        end else begin
            outcome_q <= outcome_d;
            paddr_q   <= paddr_d;
        end
    end

    assign rsp_valid = (outcome_q == OUT_HIT);
    assign rsp_fault = (outcome_q == OUT_FAULT);
    assign rsp_paddr = paddr_q;

endmodule

// File: rtl/lpt_translator.sv
// Module: top of the single-level linear page translator.
// Assumes the table is loaded before use. Responses arrive one cycle after
// the request, and writes become visible from the next sampled request.
module lpt_translator #(
    parameter int VA_W  = lpt_pkg::LPT_VA_W,
    parameter int OFF_W = lpt_pkg::LPT_OFF_W,
    parameter int ENT_W = lpt_pkg::LPT_ENT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [VA_W-OFF_W-1:0]    wr_idx,
    input  logic [ENT_W-1:0]         wr_data,
    input  logic                     req_valid,
    input  logic [VA_W-1:0]          req_vaddr,
    output logic                     rsp_valid,
    output logic                     rsp_fault,
    output logic [ENT_W-1+OFF_W-1:0] rsp_paddr
);
    localparam int IDX_W = VA_W - OFF_W;

    logic [IDX_W-1:0] rd_idx;
    logic [OFF_W-1:0] offset;
    logic [ENT_W-1:0] rd_entry;

    // Address split into index and offset
    lpt_addr_split #(.VA_W(VA_W), .OFF_W(OFF_W)) u_split (
        .vaddr  (req_vaddr),
        .idx    (rd_idx),
        .offset (offset)
    );

    // Table storage
    lpt_table_regs #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry)
    );

    // Present check and response register
    lpt_result_stage #(.ENT_W(ENT_W), .OFF_W(OFF_W)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .entry     (rd_entry),
        .offset    (offset),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_paddr (rsp_paddr)
    );

endmodule

// File: rtl/lpt_translator_chk.sv
// Module: property checker for the translator's response timing and shape.
// Assumes it observes the top's ports only. It is attached by the bind below.
module lpt_translator_chk #(
    parameter int VA_W  = 16,
    parameter int OFF_W = 12,
    parameter int ENT_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [VA_W-1:0]          req_vaddr,
    input logic                     rsp_valid,
    input logic                     rsp_fault,
    input logic [ENT_W-1+OFF_W-1:0] rsp_paddr
);
    // R4: a request always yields exactly one kind of response next cycle
    a_r4_response_due: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid || rsp_fault));

    // R7: no request means a silent cycle next
    a_r7_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault));

    // R8: valid and fault are exclusive
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_fault));

    // R9 and R5: no address is presented without a valid pulse
    a_r9_paddr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_paddr == '0));

    // R3: the page offset passes through unchanged on a hit
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_valid ||
            rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

endmodule

bind lpt_translator lpt_translator_chk #(
    .VA_W(VA_W), .OFF_W(OFF_W), .ENT_W(ENT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr)
);

// File: tb/lpt_translator_tb.sv
// Bench: fixed-seed random traffic plus directed corner cases, compared
// cycle by cycle against a table model kept inside the bench.
module lpt_translator_tb;
    localparam int VA_W  = 16;
    localparam int OFF_W = 12;
    localparam int ENT_W = 4;
    localparam int IDX_W = VA_W - OFF_W;
    localparam int PA_W  = ENT_W - 1 + OFF_W;
    localparam int NUM_ENT = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [ENT_W-1:0] wr_data;
    logic             req_valid;
    logic [VA_W-1:0]  req_vaddr;
    logic             rsp_valid;
    logic             rsp_fault;
    logic [PA_W-1:0]  rsp_paddr;

    int n_tests = 0;
    int n_fail  = 0;
    logic [ENT_W-1:0] model [NUM_ENT];

    always #2 clk = ~clk;

    lpt_translator u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    // Expected {valid, fault, paddr} from the bench's own table model
    function automatic logic [PA_W+1:0] expect_rsp(input logic rv, input logic [VA_W-1:0] va);
        logic [ENT_W-1:0] e;
        if (!rv) return '0;
        e = model[va[VA_W-1:OFF_W]];
        if (e[0]) return {1'b1, 1'b0, e[ENT_W-1:1], va[OFF_W-1:0]};
        return {1'b0, 1'b1, {PA_W{1'b0}}};
    endfunction

    task automatic check(input string tag, input logic [PA_W+1:0] act, input logic [PA_W+1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual valid/fault/paddr %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check at the next falling edge
    task automatic cycle(input logic rv, input logic [VA_W-1:0] va,
                         input logic we, input logic [IDX_W-1:0] wi,
                         input logic [ENT_W-1:0] wd, input string tag);
        logic [PA_W+1:0] exp;
        req_valid = rv; req_vaddr = va; wr_en = we; wr_idx = wi; wr_data = wd;
        exp = expect_rsp(rv, va);
        @(negedge clk);
        check(tag, {rsp_valid, rsp_fault, rsp_paddr}, exp);
        if (rsp_valid && rsp_fault) check("R8", 2'b11, 2'b10);
        if (!rsp_valid && rsp_paddr != '0) check("R9", {2'b00, rsp_paddr}, '0);
        if (we) model[wi] = wd;
        req_valid = 1'b0; wr_en = 1'b0;
    endtask

    // Watchdog: a hung run ends as a failure
    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd7331);
        for (int i = 0; i < NUM_ENT; i++) model[i] = '0;
        rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        req_valid = 1'b0; req_vaddr = '0;
        repeat (3) @(negedge clk);
        check("R1", {rsp_valid, rsp_fault, rsp_paddr}, '0);
        rst_n = 1'b1;

        // R1: every entry is not present after reset
        for (int i = 0; i < NUM_ENT; i++)
            cycle(1'b1, {IDX_W'(i), 12'hABC}, 1'b0, '0, '0, "R1");

        // R7: idle cycle is silent
        cycle(1'b0, 16'h1234, 1'b0, '0, '0, "R7");

        // R3: worked example, entry 2 = 1101, 0x2004 -> 0x6004
        cycle(1'b0, '0, 1'b1, 4'd2, 4'b1101, "R6");
        cycle(1'b1, 16'h2004, 1'b0, '0, '0, "R3");
        check("R3", {2'b00, rsp_paddr}, {2'b00, 15'h6004});

        // R6: same-edge write and read returns old content, then new
        cycle(1'b1, 16'h2FFF, 1'b1, 4'd2, 4'b0000, "R6");
        cycle(1'b1, 16'h2FFF, 1'b0, '0, '0, "R6");

        // R5: frame bits set but present clear still faults
        cycle(1'b0, '0, 1'b1, 4'd5, 4'b1110, "R5");
        cycle(1'b1, 16'h5123, 1'b0, '0, '0, "R5");

        // R4: back-to-back requests, then one idle cycle
        cycle(1'b0, '0, 1'b1, 4'd15, 4'b1111, "R4");
        cycle(1'b1, 16'hF000, 1'b0, '0, '0, "R4");
        cycle(1'b1, 16'hFFFF, 1'b0, '0, '0, "R4");
        cycle(1'b1, 16'h0001, 1'b0, '0, '0, "R4");
        cycle(1'b0, 16'hF000, 1'b0, '0, '0, "R4");

        // R2: random mix of writes and requests over all indices
        for (int i = 0; i < 600; i++) begin
            cycle(($urandom % 4) != 0, VA_W'($urandom),
                  ($urandom % 3) == 0, IDX_W'($urandom), ENT_W'($urandom), "R2");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule